// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is a small data cache placed between a processor load/store port and a slower, word-wide memory port. It holds 32 lines of 32 bytes each (1 KB) and maps every 32-bit byte address to exactly one line. A load that finds its line present returns the word combinationally in the same cycle. A load that misses raises a wait signal. The cache first lets all queued stores reach memory. It then fetches the whole line word by word and drops the wait once the line is marked present. The processor holds its request steady while the wait is high.

Stores never wait for memory. Each accepted store updates the cached word if its line is present, and it always enters a four-entry posted-write queue. The queue retires entries to memory in arrival order whenever the memory port is free. A store that misses does not bring its line in, and the line at that index stays as it was. When the queue is full, a further store is held off with the wait signal until an entry retires.

Top module: `wt_dcache`

## Requirements
- R1: A byte address splits into a word-in-line field at bits [4:2], a line index at bits [9:5] and a tag at bits [31:10]. Two addresses with equal index and different tags evict each other. Addresses with different indices can be resident together.
- R2: A load whose line is valid with a matching tag completes with `cpu_wait` low in the cycle it is presented, and `cpu_rdata` carries the stored word in that cycle.
- R3: A load that misses holds `cpu_wait` high. No memory read starts while any accepted store has not yet been acknowledged by memory.
- R4: A store to a resident line replaces that word in the cache, so a later load of the same word hits and returns the stored value.
- R5: A store that misses causes no memory read and leaves the line at its index unchanged. A load of the word still resident at that index keeps hitting with its old data.
- R6: Every accepted store is sent to memory as a write (`mem_we` = 1) with its word address and data, in acceptance order, so memory ends up holding the last value stored to each word.
- R7: The posted-write queue holds 4 stores. With memory not acknowledging, four stores are accepted without wait. A fifth store sees `cpu_wait` high until an entry retires.
- R8: After reset no line is valid, the queue is empty and `mem_req` is low.
- R9: Once `mem_req` is raised, it stays high with the same `mem_addr` and `mem_we` until `mem_ack` is seen. A memory read (`mem_we` = 0) acknowledged with `mem_ack` returns its word on `mem_rdata` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held while `cpu_wait` is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address; bits [1:0] are ignored |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a load completes |
| cpu_wait | output | 1 | Access not yet complete; processor must hold it |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Current memory operation completes this cycle |

## Verification
The bench builds the block with its default parameters: 32-byte lines, 32 lines and a 4-deep queue. Random addresses are confined to 4 tags and 8 indices, so evictions, hit-after-fill and store-miss-then-load sequences occur often. A slow-memory phase and a phase where memory never acknowledges bring queue saturation within reach. The random memory latency makes the drain-before-refill ordering and the request hold rule happen under varied timing.

// File: rtl/wt_dcache_pkg.sv
`timescale 1ns/1ps
package wt_dcache_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int BYTE_OFF = $clog2(DATA_W / 8);
    localparam int WADDR_W  = ADDR_W - BYTE_OFF;

    typedef enum logic {
        FILL_IDLE,
        FILL_RUN
    } fill_state_e;

    typedef struct packed {
        logic [WADDR_W-1:0] waddr;
        logic [DATA_W-1:0]  data;
    } post_entry_t;

    function automatic logic [ADDR_W-1:0] word_to_byte(input logic [WADDR_W-1:0] w);
        return {w, {BYTE_OFF{1'b0}}};
    endfunction

endpackage

// File: rtl/wt_line_store.sv
`timescale 1ns/1ps
module wt_line_store
    import wt_dcache_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int WORDS     = 8,
    parameter int TAG_W     = 22,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int WRD_W    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [WRD_W-1:0]  lk_word,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WRD_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);

    logic              line_ok [NUM_LINES];
    logic [TAG_W-1:0]  tags    [NUM_LINES];
    logic [DATA_W-1:0] words   [NUM_LINES*WORDS];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                line_ok[g] <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                line_ok[g] <= 1'b1;
            end else if (clr_en && clr_idx == IDX_W'(g)) begin
                line_ok[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) begin
            tags[set_idx] <= set_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[{wr_idx, wr_word}] <= wr_data;
        end
    end

    assign lk_hit  = line_ok[lk_idx] && (tags[lk_idx] == lk_tag);
    assign lk_data = words[{lk_idx, lk_word}];

endmodule

// File: rtl/wt_post_fifo.sv
`timescale 1ns/1ps
module wt_post_fifo
    import wt_dcache_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  post_entry_t din,
    input  logic        pop,
    output post_entry_t dout,
    output logic        full,
    output logic        empty
);

    post_entry_t       slots [DEPTH];
    logic [PW-1:0]     wp, rp;
    logic [CW-1:0]     fill;
    logic              do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wp] <= din;
        end
    end

    assign dout  = slots[rp];
    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);

endmodule

// File: rtl/wt_refill_ctrl.sv
`timescale 1ns/1ps
module wt_refill_ctrl
    import wt_dcache_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int IDX_W  = 5,
    parameter int TAG_W  = 22,
    localparam int WRD_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [TAG_W-1:0] start_tag,
    input  logic             ack,
    output logic             busy,
    output logic [IDX_W-1:0] line_idx,
    output logic [TAG_W-1:0] line_tag,
    output logic [WRD_W-1:0] word_sel,
    output logic             last_beat
);

    fill_state_e      state;
    logic [WRD_W-1:0] beat;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic             at_end;

    assign at_end = (beat == WRD_W'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FILL_IDLE;
            beat  <= '0;
            idx_q <= '0;
            tag_q <= '0;
        end else begin
            case (state)
                FILL_IDLE: begin
                    if (start) begin
                        state <= FILL_RUN;
                        beat  <= '0;
                        idx_q <= start_idx;
                        tag_q <= start_tag;
                    end
                end
                FILL_RUN: begin
                    if (ack) begin
                        beat <= beat + 1'b1;
                        if (at_end) state <= FILL_IDLE;
                    end
                end
                default: state <= FILL_IDLE;
            endcase
        end
    end

    assign busy      = (state == FILL_RUN);
    assign line_idx  = idx_q;
    assign line_tag  = tag_q;
    assign word_sel  = beat;
    assign last_beat = busy && ack && at_end;

endmodule

// File: rtl/wt_dcache.sv
`timescale 1ns/1ps
module wt_dcache
    import wt_dcache_pkg::*;
#(
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 32,
    parameter int POST_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_wait,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    localparam int WORDS = LINE_BYTES / (DATA_W / 8);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int WRD_W = $clog2(WORDS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [WRD_W-1:0] a_word;
    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    logic             unused_lo;

    assign a_word    = cpu_addr[OFF_W-1:BYTE_OFF];
    assign a_idx     = cpu_addr[OFF_W+IDX_W-1:OFF_W];
    assign a_tag     = cpu_addr[ADDR_W-1:OFF_W+IDX_W];
    assign unused_lo = ^cpu_addr[BYTE_OFF-1:0];

    logic              hit;
    logic [DATA_W-1:0] hit_data;
    logic              q_full, q_empty, q_push, q_pop;
    post_entry_t       q_in, q_head;
    logic              f_busy, f_start, f_last;
    logic [IDX_W-1:0]  f_idx;
    logic [TAG_W-1:0]  f_tag;
    logic [WRD_W-1:0]  f_word;
    logic              st_wr;
    logic [IDX_W-1:0]  st_idx;
    logic [WRD_W-1:0]  st_word;
    logic [DATA_W-1:0] st_data;
    logic              ld_req, st_req;

    assign ld_req  = cpu_req && !cpu_we;
    assign st_req  = cpu_req && cpu_we;

    assign f_start = ld_req && !hit && q_empty && !f_busy;
    assign q_push  = st_req && !q_full;
    assign q_pop   = !f_busy && !q_empty && mem_ack;
    assign q_in    = '{waddr: cpu_addr[ADDR_W-1:BYTE_OFF], data: cpu_wdata};

    always_comb begin
        if (f_busy) begin
            st_wr   = mem_ack;
            st_idx  = f_idx;
            st_word = f_word;
            st_data = mem_rdata;
        end else begin
            st_wr   = q_push && hit;
            st_idx  = a_idx;
            st_word = a_word;
            st_data = cpu_wdata;
        end
    end

    wt_line_store #(
        .NUM_LINES (NUM_LINES),
        .WORDS     (WORDS),
        .TAG_W     (TAG_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .lk_idx  (a_idx),
        .lk_word (a_word),
        .lk_tag  (a_tag),
        .lk_hit  (hit),
        .lk_data (hit_data),
        .wr_en   (st_wr),
        .wr_idx  (st_idx),
        .wr_word (st_word),
        .wr_data (st_data),
        .set_en  (f_last),
        .set_idx (f_idx),
        .set_tag (f_tag),
        .clr_en  (f_start),
        .clr_idx (a_idx)
    );

    wt_post_fifo #(
        .DEPTH (POST_DEPTH)
    ) u_post (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .din   (q_in),
        .pop   (q_pop),
        .dout  (q_head),
        .full  (q_full),
        .empty (q_empty)
    );

    wt_refill_ctrl #(
        .WORDS (WORDS),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_fill (
        .clk       (clk),
        .rst       (rst),
        .start     (f_start),
        .start_idx (a_idx),
        .start_tag (a_tag),
        .ack       (mem_ack),
        .busy      (f_busy),
        .line_idx  (f_idx),
        .line_tag  (f_tag),
        .word_sel  (f_word),
        .last_beat (f_last)
    );

    assign cpu_rdata = hit_data;
    assign cpu_wait  = cpu_req && (cpu_we ? q_full : !hit);

    assign mem_req   = f_busy || !q_empty;
    assign mem_we    = !f_busy;
    assign mem_addr  = f_busy ? word_to_byte({f_tag, f_idx, f_word}) : word_to_byte(q_head.waddr);
    assign mem_wdata = q_head.data;

endmodule

// File: rtl/wt_dcache_chk.sv
`timescale 1ns/1ps
module wt_dcache_chk
    import wt_dcache_pkg::*;
#(
    parameter int LINE_BYTES = 32,
    localparam int WPL       = LINE_BYTES / (DATA_W / 8)
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_wait,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);

    // R3
    fill_stalls_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (cpu_req && !cpu_we && cpu_wait));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && (mem_we ? $stable(mem_wdata) : 1'b1)));

    // R6
    store_posted_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !cpu_wait) |=> mem_req);

    // R3
    fill_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack && (((mem_addr >> BYTE_OFF) & (WPL - 1)) != (WPL - 1)))
        |=> (mem_req && !mem_we && (mem_addr == $past(mem_addr) + ADDR_W'(DATA_W / 8))));

    // R2
    hit_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && !cpu_wait) |-> !(mem_req && !mem_we));

endmodule

bind wt_dcache wt_dcache_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_wait  (cpu_wait),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/tb_wt_dcache.sv
`timescale 1ns/1ps
module tb_wt_dcache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_wait;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    wt_dcache dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #4 clk = ~clk;

    // memory model state (driven only by the model process)
    logic [31:0] bmem [1024];
    int          lat = 0;
    int          wr_acks = 0;
    int          order_err = 0;
    int          drain_err = 0;
    int          hold_err = 0;
    logic [31:0] next_fill = '0;
    bit          p_req = 0, p_ack = 0, p_we = 0;
    logic [31:0] p_addr = '0;

    // stimulus-side state
    bit          slow = 0;
    bit          mem_hold = 0;
    int          push_cnt = 0;
    logic [31:0] ref_mem [1024];
    bit          sh_ok [32];
    logic [21:0] sh_tag [32];
    int          checks = 0;
    int          fails = 0;

    function automatic logic [31:0] init_word(input int i);
        return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) bmem[i] = init_word(i);
            mem_ack = 1'b0;
            p_req = 0;
            p_ack = 0;
        end else begin
            // R9: request held until acknowledged
            if (p_req && !p_ack && (!mem_req || mem_addr != p_addr || mem_we != p_we)) hold_err++;
            p_req  = mem_req;
            p_addr = mem_addr;
            p_we   = mem_we;
            if (mem_ack) begin
                mem_ack = 1'b0;
                lat = slow ? int'($urandom % 7) : int'($urandom % 4);
            end else if (mem_req && !mem_hold) begin
                if (lat == 0) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        bmem[mem_addr[11:2]] = mem_wdata;
                        wr_acks++;
                    end else begin
                        mem_rdata = bmem[mem_addr[11:2]];
                        if (push_cnt != wr_acks) drain_err++;
                        if (mem_addr[4:2] == 3'd0) next_fill = mem_addr;
                        if (mem_addr != next_fill) order_err++;
                        next_fill = mem_addr + 32'd4;
                    end
                end else begin
                    lat--;
                end
            end
            p_ack = mem_ack;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output bit waited);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        waited = cpu_wait;
        while (cpu_wait) begin
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        if (we) push_cnt++;
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    task automatic rd_chk(input logic [31:0] a, input string req, input int expect_hit);
        logic [31:0] rd;
        bit          w;
        bit          sh_hit;
        sh_hit = sh_ok[a[9:5]] && (sh_tag[a[9:5]] == a[31:10]);
        access(1'b0, a, '0, rd, w);
        if (expect_hit >= 0) chk(sh_hit == bit'(expect_hit), req, "bench hit model", 32'(sh_hit), 32'(expect_hit));
        chk(w == !sh_hit, req, "load wait vs hit", 32'(w), 32'(!sh_hit));
        chk(rd == ref_mem[a[11:2]], req, "load data", rd, ref_mem[a[11:2]]);
        sh_ok[a[9:5]] = 1'b1;
        sh_tag[a[9:5]] = a[31:10];
    endtask

    task automatic wr_do(input logic [31:0] a, input logic [31:0] d, output bit w);
        logic [31:0] rd;
        access(1'b1, a, d, rd, w);
        ref_mem[a[11:2]] = d;
    endtask

    task automatic drain();
        int guard = 0;
        while (mem_req && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        bit w;
        int mm;
        void'($urandom(32'd4711));
        for (int i = 0; i < 1024; i++) ref_mem[i] = init_word(i);
        for (int i = 0; i < 32; i++) begin sh_ok[i] = 0; sh_tag[i] = '0; end
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R8: reset leaves the memory port idle and every line invalid
        chk(mem_req == 1'b0, "R8", "mem_req after reset", 32'(mem_req), 32'd0);
        rd_chk(32'h0000_00A0, "R8", 0);
        // R2: neighbouring word of a filled line hits
        rd_chk(32'h0000_00A4, "R2", 1);
        // R4: store hit then load
        wr_do(32'h0000_00A8, 32'h1234_5678, w);
        chk(w == 1'b0, "R4", "store wait on empty queue", 32'(w), 32'd0);
        rd_chk(32'h0000_00A8, "R4", 1);
        // R1: same index, other tag evicts; other index coexists
        rd_chk(32'h0000_04A0, "R1", 0);
        rd_chk(32'h0000_00A0, "R1", 0);
        rd_chk(32'h0000_00C0, "R1", 0);
        rd_chk(32'h0000_00A4, "R1", 1);
        rd_chk(32'h0000_00C4, "R1", 1);
        // R5: store miss leaves line unchanged, no fetch
        wr_do(32'h0000_04C8, 32'hCAFE_F00D, w);
        rd_chk(32'h0000_00C8, "R5", 1);
        rd_chk(32'h0000_04C8, "R5", 0);
        // R7: queue depth 4 with memory halted
        drain();
        mem_hold = 1;
        for (int k = 0; k < 4; k++) begin
            wr_do(32'h0000_0100 + 32'(k * 4), 32'hB000_0000 + 32'(k), w);
            chk(w == 1'b0, "R7", "store within depth", 32'(w), 32'd0);
        end
        fork
            begin repeat (6) @(posedge clk); mem_hold = 0; end
        join_none
        wr_do(32'h0000_0110, 32'hB000_0004, w);
        chk(w == 1'b1, "R7", "fifth store stalled", 32'(w), 32'd1);
        rd_chk(32'h0000_0110, "R6", -1);
        // random phase
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] a;
            slow = (n >= 1000);
            a = {20'd0, 2'($urandom), 2'b00, 3'($urandom), 3'($urandom), 2'b00};
            if (($urandom % 3) == 0) wr_do(a, $urandom, w);
            else rd_chk(a, "R2", -1);
        end
        drain();
        mm = 0;
        for (int i = 0; i < 1024; i++) if (bmem[i] !== ref_mem[i]) mm++;
        chk(mm == 0, "R6", "memory words differing", 32'(mm), 32'd0);
        chk(push_cnt == wr_acks, "R6", "stores written to memory", 32'(wr_acks), 32'(push_cnt));
        chk(order_err == 0, "R3", "refill word order errors", 32'(order_err), 32'd0);
        chk(drain_err == 0, "R3", "refill before queue drained", 32'(drain_err), 32'd0);
        chk(hold_err == 0, "R9", "request changed before ack", 32'(hold_err), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule